// File: doc/BRIEF.md
# Asynchronous Serial Port with Sticky Frame Check

This block is a full-duplex asynchronous serial port. Software reaches it through three byte-wide registers: a control/status register, a power/option register and a data register. The transmitter and receiver run at the same time and each has its own baud tick input, so the two directions may run at different rates. Each tick is one oversampling slot, and a bit lasts 16 effective slots. Three frame formats are supported: an 8-bit format and two 9-bit formats. In the 9-bit formats the ninth transmitted bit comes from a control bit, and the ninth received bit is returned in another control bit.

An option bit turns on stop-bit checking. When it is on, a stop bit sampled low sets a sticky error flag. This flag sits at the same control-register position as the upper mode-code bit, and the option bit decides which of the two that position reads and writes. Turning checking on also moves the receive-complete flag in the 9-bit formats from the ninth bit to the stop bit. The transmit-done and receive-complete flags are ORed onto one interrupt line.

Top module: `sio_port`

## Requirements
- R1: After reset, the control and option registers read 0x00, `txd_o` is 1 and `irq_o` is 0.
- R2: With mode code 01 (control bits 7:6), writing the data register (address 1) sends a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. Each bit lasts 16 effective ticks. The transmit-done flag (control bit 1) sets when the frame ends.
- R3: With mode code 10 or 11, the transmitted frame carries control bit 3 as a ninth bit between the data bits and the stop bit.
- R4: With mode code 01 and receive enable (control bit 4) set, a received frame places its byte in the data register. The stop bit value goes to control bit 2 and the receive-complete flag (control bit 0) sets.
- R5: With mode code 10 or 11, the ninth received bit goes to control bit 2.
- R6: With stop checking on (option bit 6), control bit 7 reads and writes the error flag, and a stop bit sampled as 0 sets that flag. With checking off, control bit 7 reads and writes the upper mode-code bit.
- R7: The error flag stays set through later frames with a valid stop bit. Only a control write of 0 to bit 7 while checking is on, or reset, clears it.
- R8: In the 9-bit formats, receive-complete rises exactly 16 effective ticks later with checking on than with checking off.
- R9: A frame that completes while receive-complete is still set is dropped: the data register keeps the earlier byte.
- R10: `irq_o` is high exactly when transmit-done or receive-complete is set.
- R11: With the double-rate bit (option bit 7) clear, only every second tick is used, so a bit lasts 32 raw ticks. With the bit set, a bit lasts 16 raw ticks.
- R12: With receive enable clear, incoming frames are ignored.
- R13: A data-register write made while a frame is being sent is ignored.
- R14: A low pulse on `rxd_i` that has returned high by the middle of the start bit starts no reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select: 0 control, 1 data, 2 option |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected register (combinational) |
| rxd_i | input | 1 | Serial input line |
| txd_o | output | 1 | Serial output line |
| rx_tick_i | input | 1 | Receive oversampling tick |
| tx_tick_i | input | 1 | Transmit oversampling tick |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong bit counter or shift register in the transmitter shows as a wrong level on `txd_o` at the middle of the affected bit, during the frame being sent. A receiver fault shows within one frame: a wrong byte on a data-register read, a wrong ninth-bit copy, or receive-complete rising at the wrong slot. Both frame formats are tested, with checking on and off. Faults in the error flag's stickiness or in the bit-7 sharing appear on the next control-register read after a bad frame, a good frame or a rewrite.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned OSR    = 16;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [1:0] {
        REG_CTL  = 2'd0,
        REG_DATA = 2'd1,
        REG_OPT  = 2'd2
    } reg_sel_e;

    typedef enum logic [1:0] {
        FMT_OFF = 2'b00,
        FMT_8   = 2'b01,
        FMT_9A  = 2'b10,
        FMT_9B  = 2'b11
    } fmt_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RUN  = 1'b1
    } rx_state_e;

    localparam int unsigned CB_SHARED = 7;
    localparam int unsigned CB_FMT_LO = 6;
    localparam int unsigned CB_REN    = 4;
    localparam int unsigned CB_TX9    = 3;
    localparam int unsigned CB_RX9    = 2;
    localparam int unsigned CB_TDONE  = 1;
    localparam int unsigned CB_RDONE  = 0;
    localparam int unsigned OB_DBL    = 7;
    localparam int unsigned OB_CHK    = 6;

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic fmt_nine(input fmt_e f);
        return (f == FMT_9A) || (f == FMT_9B);
    endfunction

endpackage

// File: rtl/sio_tick_gate.sv
module sio_tick_gate (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic dbl_i,
    output logic tick_o
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst)         phase_q <= 1'b0;
        else if (tick_i) phase_q <= ~phase_q;
    end

    assign tick_o = tick_i & (dbl_i | phase_q);
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
    parameter int unsigned DATA_W = sio_pkg::DATA_W,
    parameter int unsigned OSR    = sio_pkg::OSR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic              nine_i,
    input  logic              bit9_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              txd_o
);
    localparam int unsigned FRAME_MAX = DATA_W + 3;
    localparam int unsigned IDX_W     = $clog2(FRAME_MAX + 1);
    localparam int unsigned OCNT_W    = $clog2(OSR);

    logic                 busy_q, done_q;
    logic [FRAME_MAX-1:0] sh_q;
    logic [IDX_W-1:0]     nbits_q, bidx_q;
    logic [OCNT_W-1:0]    ocnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            sh_q    <= '1;
            nbits_q <= '0;
            bidx_q  <= '0;
            ocnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q  <= 1'b1;
                    sh_q    <= {1'b1, (nine_i ? bit9_i : 1'b1), data_i, 1'b0};
                    nbits_q <= nine_i ? IDX_W'(DATA_W + 3) : IDX_W'(DATA_W + 2);
                    bidx_q  <= '0;
                    ocnt_q  <= '0;
                end
            end else if (tick_i) begin
                if (ocnt_q == OCNT_W'(OSR - 1)) begin
                    ocnt_q <= '0;
                    sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
                    if (bidx_q == nbits_q - IDX_W'(1)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bidx_q <= bidx_q + IDX_W'(1);
                    end
                end else begin
                    ocnt_q <= ocnt_q + OCNT_W'(1);
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign txd_o  = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
    parameter int unsigned DATA_W = sio_pkg::DATA_W,
    parameter int unsigned OSR    = sio_pkg::OSR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic              en_i,
    input  logic              nine_i,
    input  logic              chk_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              bit9_o,
    output logic              stop_bad_o
);
    import sio_pkg::*;

    localparam int unsigned IDX_W  = $clog2(DATA_W + 4);
    localparam int unsigned OCNT_W = $clog2(OSR);
    localparam int unsigned MID    = OSR / 2 + 1;
    localparam logic [IDX_W-1:0] IDX_B9   = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(DATA_W + 2);

    rx_state_e         state_q;
    logic              s1_q, s2_q, sp_q;
    logic [OCNT_W-1:0] ocnt_q;
    logic [IDX_W-1:0]  bidx_q;
    logic [1:0]        samp_q;
    logic [DATA_W-1:0] shreg_q, dout_q;
    logic              b9_q, bad_q, done_q, b9o_q, bado_q;

    logic             bit_now, stop_bad_now;
    logic [IDX_W-1:0] stop_idx, last_idx;

    assign bit_now      = maj3({s2_q, samp_q});
    assign stop_idx     = nine_i ? IDX_STOP : IDX_B9;
    assign last_idx     = (chk_i && nine_i) ? IDX_STOP : IDX_B9;
    assign stop_bad_now = (bidx_q == stop_idx) && chk_i && !bit_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q    <= 1'b1;
            s2_q    <= 1'b1;
            sp_q    <= 1'b1;
            state_q <= RX_IDLE;
            ocnt_q  <= '0;
            bidx_q  <= '0;
            samp_q  <= '0;
            shreg_q <= '0;
            b9_q    <= 1'b0;
            bad_q   <= 1'b0;
            done_q  <= 1'b0;
            dout_q  <= '0;
            b9o_q   <= 1'b0;
            bado_q  <= 1'b0;
        end else begin
            s1_q   <= rxd_i;
            s2_q   <= s1_q;
            sp_q   <= s2_q;
            done_q <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (en_i && sp_q && !s2_q) begin
                        state_q <= RX_RUN;
                        ocnt_q  <= '0;
                        bidx_q  <= '0;
                        bad_q   <= 1'b0;
                    end
                end
                default: begin
                    if (tick_i) begin
                        if (ocnt_q == OCNT_W'(OSR - 1)) begin
                            ocnt_q <= '0;
                            bidx_q <= bidx_q + IDX_W'(1);
                        end else begin
                            ocnt_q <= ocnt_q + OCNT_W'(1);
                        end
                        if (ocnt_q == OCNT_W'(MID - 2)) samp_q[0] <= s2_q;
                        if (ocnt_q == OCNT_W'(MID - 1)) samp_q[1] <= s2_q;
                        if (ocnt_q == OCNT_W'(MID)) begin
                            if (bidx_q == '0) begin
                                if (bit_now) state_q <= RX_IDLE;
                            end else if (bidx_q <= IDX_W'(DATA_W)) begin
                                shreg_q <= {bit_now, shreg_q[DATA_W-1:1]};
                            end
                            if (bidx_q == IDX_B9) b9_q <= bit_now;
                            if (stop_bad_now) bad_q <= 1'b1;
                            if (bidx_q == last_idx) begin
                                state_q <= RX_IDLE;
                                done_q  <= 1'b1;
                                dout_q  <= shreg_q;
                                b9o_q   <= (bidx_q == IDX_B9) ? bit_now : b9_q;
                                bado_q  <= bad_q | stop_bad_now;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign busy_o     = (state_q == RX_RUN);
    assign done_o     = done_q;
    assign data_o     = dout_q;
    assign bit9_o     = b9o_q;
    assign stop_bad_o = bado_q;
endmodule

// File: rtl/sio_port.sv
module sio_port (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr_i,
    input  logic [1:0] bus_addr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    input  logic       rxd_i,
    output logic       txd_o,
    input  logic       rx_tick_i,
    input  logic       tx_tick_i,
    output logic       irq_o
);
    import sio_pkg::*;

    logic [1:0]        fmt_q;
    logic              ren_q, tx9_q, rx9_q, ti_q, ri_q, fe_q, dbl_q, chk_q;
    logic [DATA_W-1:0] rxbuf_q;

    logic              ctl_wr, opt_wr, data_wr, rx_en, nine;
    logic              tx_tick_g, rx_tick_g;
    logic              tx_busy, tx_done, rx_busy, rx_done, rx_b9, rx_bad;
    logic [DATA_W-1:0] rx_data;

    assign ctl_wr  = bus_wr_i && (reg_sel_e'(bus_addr_i) == REG_CTL);
    assign data_wr = bus_wr_i && (reg_sel_e'(bus_addr_i) == REG_DATA);
    assign opt_wr  = bus_wr_i && (reg_sel_e'(bus_addr_i) == REG_OPT);
    assign nine    = fmt_nine(fmt_e'(fmt_q));
    assign rx_en   = ren_q && (fmt_e'(fmt_q) != FMT_OFF);

    sio_tick_gate tx_gate_i (
        .clk(clk), .rst(rst), .tick_i(tx_tick_i), .dbl_i(dbl_q), .tick_o(tx_tick_g)
    );
    sio_tick_gate rx_gate_i (
        .clk(clk), .rst(rst), .tick_i(rx_tick_i), .dbl_i(dbl_q), .tick_o(rx_tick_g)
    );

    sio_tx #(.DATA_W(DATA_W), .OSR(OSR)) tx_i (
        .clk(clk), .rst(rst), .tick_i(tx_tick_g),
        .start_i(data_wr && (fmt_e'(fmt_q) != FMT_OFF)),
        .nine_i(nine), .bit9_i(tx9_q), .data_i(bus_wdata_i[DATA_W-1:0]),
        .busy_o(tx_busy), .done_o(tx_done), .txd_o(txd_o)
    );

    sio_rx #(.DATA_W(DATA_W), .OSR(OSR)) rx_i (
        .clk(clk), .rst(rst), .tick_i(rx_tick_g), .rxd_i(rxd_i),
        .en_i(rx_en), .nine_i(nine), .chk_i(chk_q),
        .busy_o(rx_busy), .done_o(rx_done), .data_o(rx_data),
        .bit9_o(rx_b9), .stop_bad_o(rx_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q   <= 2'b00;
            ren_q   <= 1'b0;
            tx9_q   <= 1'b0;
            rx9_q   <= 1'b0;
            ti_q    <= 1'b0;
            ri_q    <= 1'b0;
            fe_q    <= 1'b0;
            dbl_q   <= 1'b0;
            chk_q   <= 1'b0;
            rxbuf_q <= '0;
        end else begin
            if (ctl_wr) begin
                if (chk_q) fe_q <= bus_wdata_i[CB_SHARED];
                else       fmt_q[1] <= bus_wdata_i[CB_SHARED];
                fmt_q[0] <= bus_wdata_i[CB_FMT_LO];
                ren_q    <= bus_wdata_i[CB_REN];
                tx9_q    <= bus_wdata_i[CB_TX9];
                rx9_q    <= bus_wdata_i[CB_RX9];
                ti_q     <= bus_wdata_i[CB_TDONE];
                ri_q     <= bus_wdata_i[CB_RDONE];
            end
            if (opt_wr) begin
                dbl_q <= bus_wdata_i[OB_DBL];
                chk_q <= bus_wdata_i[OB_CHK];
            end
            if (tx_done) ti_q <= 1'b1;
            if (rx_done) begin
                if (rx_bad) fe_q <= 1'b1;
                if (!ri_q) begin
                    ri_q    <= 1'b1;
                    rxbuf_q <= rx_data;
                    rx9_q   <= rx_b9;
                end
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (reg_sel_e'(bus_addr_i))
            REG_CTL:  bus_rdata_o = {(chk_q ? fe_q : fmt_q[1]), fmt_q[0], 1'b0,
                                     ren_q, tx9_q, rx9_q, ti_q, ri_q};
            REG_DATA: bus_rdata_o = rxbuf_q;
            REG_OPT:  bus_rdata_o = {dbl_q, chk_q, 6'b0};
            default:  bus_rdata_o = '0;
        endcase
    end

    assign irq_o = ti_q | ri_q;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       txd_o,
    input logic       tx_busy,
    input logic       tx_done,
    input logic       ti_q,
    input logic       fe_q,
    input logic       ctl_wr,
    input logic       ri_q,
    input logic [7:0] rxbuf_q,
    input logic       rx_busy,
    input logic       rx_en,
    input logic       dbl_q,
    input logic       tx_tick_g
);
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> !txd_o); // R2
    AST_DONE_SETS_TI: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> ti_q); // R2
    AST_FE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fe_q && !ctl_wr) |=> fe_q); // R7
    AST_FULL_BUF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ri_q && !ctl_wr) |=> $stable(rxbuf_q)); // R9
    AST_RX_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!rx_busy && !rx_en) |=> !rx_busy); // R12
    AST_HALF_RATE_GAP: assert property (@(posedge clk) disable iff (rst)
        (!dbl_q && tx_tick_g) |=> (dbl_q || !tx_tick_g)); // R11
endmodule

bind sio_port sio_port_chk chk_i (
    .clk(clk), .rst(rst), .txd_o(txd_o), .tx_busy(tx_busy), .tx_done(tx_done),
    .ti_q(ti_q), .fe_q(fe_q), .ctl_wr(ctl_wr), .ri_q(ri_q), .rxbuf_q(rxbuf_q),
    .rx_busy(rx_busy), .rx_en(rx_en), .dbl_q(dbl_q), .tx_tick_g(tx_tick_g)
);

// File: tb/sio_port_tb_top.sv
`timescale 1ns/1ps
module sio_port_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd, irq;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sio_port dut_i (
        .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .rxd_i(rxd),
        .txd_o(txd), .rx_tick_i(1'b1), .tx_tick_i(1'b1), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cap_tx(input int n, input int per, output logic [11:0] bits);
        int w = 0;
        bits = '1;
        while (txd && w < 2000) begin @(negedge clk); w++; end
        repeat (per / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            bits[i] = txd;
            repeat (per) @(negedge clk);
        end
    endtask

    task automatic send_rx(input logic [11:0] bits, input int n, input int per);
        for (int i = 0; i < n; i++) begin
            rxd = bits[i];
            repeat (per) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic timed_rx(input logic [11:0] bits, output int t);
        int c = 0;
        fork
            send_rx(bits, 11, 16);
            begin
                while (!irq && c < 400) begin @(negedge clk); c++; end
            end
        join
        t = c;
    endtask

    initial begin
        #900000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  r;
        logic [11:0] got, exp;
        int t_off, t_on;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, r); chk(r == 8'h00, "R1", "ctl", r, 0);
        rd(2'd2, r); chk(r == 8'h00, "R1", "opt", r, 0);
        chk(txd == 1'b1, "R1", "txd", txd, 1);
        chk(irq == 1'b0, "R1", "irq", irq, 0);

        // R2 8-bit transmit sweep, R10 irq
        wr(2'd2, 8'h80);
        wr(2'd0, 8'h50);
        for (int v = 0; v < 256; v += 17) begin
            wr(2'd1, 8'(v));
            cap_tx(10, 16, got);
            exp = {2'b11, 1'b1, 8'(v), 1'b0};
            chk(got[9:0] == exp[9:0], "R2", "tx frame", got[9:0], exp[9:0]);
            rd(2'd0, r); chk(r[1] == 1'b1, "R2", "tdone flag", r[1], 1);
            chk(irq == 1'b1, "R10", "irq on tdone", irq, 1);
            wr(2'd0, 8'h50);
            chk(irq == 1'b0, "R10", "irq cleared", irq, 0);
        end

        // R13 write while busy ignored
        wr(2'd1, 8'hA5);
        wr(2'd1, 8'h3C);
        cap_tx(10, 16, got);
        chk(got[9:0] == {1'b1, 8'hA5, 1'b0}, "R13", "first frame kept", got[9:0], {1'b1, 8'hA5, 1'b0});
        begin
            int lows = 0;
            for (int i = 0; i < 300; i++) begin @(negedge clk); if (!txd) lows++; end
            chk(lows == 0, "R13", "no second frame", lows, 0);
        end
        wr(2'd0, 8'h50);

        // R11 half-rate ticks
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h96);
        cap_tx(10, 32, got);
        chk(got[9:0] == {1'b1, 8'h96, 1'b0}, "R11", "32-tick bits", got[9:0], {1'b1, 8'h96, 1'b0});
        wr(2'd2, 8'h80);
        wr(2'd0, 8'h50);

        // R3 nine-bit transmit, both 9-bit codes
        for (int k = 0; k < 6; k++) begin
            logic b9 = k[0];
            logic [7:0] d = 8'(k * 41 + 3);
            wr(2'd0, (k < 3 ? 8'h90 : 8'hD0) | (b9 ? 8'h08 : 8'h00));
            wr(2'd1, d);
            cap_tx(11, 16, got);
            exp = {1'b1, 1'b1, b9, d, 1'b0};
            chk(got[10:0] == exp[10:0], "R3", "9-bit tx frame", got[10:0], exp[10:0]);
        end

        // R4 8-bit receive sweep
        wr(2'd0, 8'h50);
        for (int v = 5; v < 256; v += 19) begin
            send_rx({3'b111, 8'(v), 1'b0}, 10, 16);
            rd(2'd1, r); chk(r == 8'(v), "R4", "rx byte", r, v);
            rd(2'd0, r); chk(r[0] && r[2], "R4", "rdone and stop copy", r[2:0], 3'b101);
            chk(irq == 1'b1, "R10", "irq on rdone", irq, 1);
            wr(2'd0, 8'h50);
        end

        // R5 nine-bit receive
        wr(2'd0, 8'h90);
        for (int k = 0; k < 4; k++) begin
            logic b9 = k[0];
            logic [7:0] d = 8'(8'hC3 ^ (k * 37));
            send_rx({2'b11, b9, d, 1'b0}, 11, 16);
            rd(2'd1, r); chk(r == d, "R5", "rx byte", r, d);
            rd(2'd0, r); chk(r[2] == b9 && r[0], "R5", "ninth bit", r[2], b9);
            wr(2'd0, 8'h90);
        end

        // R12 receive disabled
        wr(2'd0, 8'h40);
        send_rx({3'b111, 8'h5A, 1'b0}, 10, 16);
        rd(2'd0, r); chk(r[0] == 1'b0, "R12", "no rdone", r[0], 0);
        rd(2'd1, r); chk(r != 8'h5A, "R12", "buffer untouched", r, 0);

        // R14 start glitch
        wr(2'd0, 8'h50);
        rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
        repeat (300) @(negedge clk);
        rd(2'd0, r); chk(r[0] == 1'b0, "R14", "no rx after glitch", r[0], 0);
        send_rx({3'b111, 8'h81, 1'b0}, 10, 16);
        rd(2'd1, r); chk(r == 8'h81, "R14", "next frame ok", r, 8'h81);

        // R9 dropped while rdone set
        send_rx({3'b111, 8'h18, 1'b0}, 10, 16);
        rd(2'd1, r); chk(r == 8'h81, "R9", "buffer kept", r, 8'h81);
        rd(2'd0, r); chk(r[0] == 1'b1, "R9", "rdone still set", r[0], 1);
        wr(2'd0, 8'h50);

        // R6 stop check and shared bit 7
        wr(2'd2, 8'hC0);
        wr(2'd0, 8'h50);
        rd(2'd0, r); chk(r[7] == 1'b0, "R6", "flag clear", r[7], 0);
        send_rx({3'b000, 8'h66, 1'b0}, 10, 16);
        rd(2'd0, r); chk(r[7] == 1'b1, "R6", "bad stop sets flag", r[7], 1);
        chk(r[2] == 1'b0, "R4", "stop copy low", r[2], 0);
        rd(2'd1, r); chk(r == 8'h66, "R6", "byte kept", r, 8'h66);
        wr(2'd2, 8'h80);
        rd(2'd0, r); chk(r[7:6] == 2'b01, "R6", "bit7 is mode bit", r[7:6], 1);
        wr(2'd2, 8'hC0);

        // R7 sticky flag
        wr(2'd0, 8'hD0);
        send_rx({3'b111, 8'h24, 1'b0}, 10, 16);
        rd(2'd0, r); chk(r[7] == 1'b1, "R7", "flag survives good frame", r[7], 1);
        rd(2'd1, r); chk(r == 8'h24, "R7", "good byte", r, 8'h24);
        wr(2'd0, 8'h50);
        rd(2'd0, r); chk(r[7] == 1'b0, "R7", "write 0 clears", r[7], 0);

        // R8 completion point moves by one bit
        wr(2'd2, 8'h80);
        wr(2'd0, 8'h90);
        timed_rx({2'b11, 1'b1, 8'h3E, 1'b0}, t_off);
        wr(2'd0, 8'h90);
        wr(2'd2, 8'hC0);
        wr(2'd0, 8'h10);
        timed_rx({2'b11, 1'b1, 8'h3E, 1'b0}, t_on);
        chk(t_on - t_off == 16, "R8", "rdone delay shift", t_on - t_off, 16);
        rd(2'd0, r); chk(r[7] == 1'b0, "R8", "no flag on good stop", r[7], 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule